// File: doc/BRIEF.md
# Register-Indexed Cache Access Memo Table

This block keeps, for every architectural register, the cache-access facts that an address-preparation operation worked out for the address held in that register. A preparation operation writes the entry of its destination register with the chosen data-cache way, the cache set index, the physical page number and two valid flags. A later load or store names its base register on the read port and gets the entry back in the same cycle. One flag says the recorded way is still good, so the access can read a single data way without any tag compare. The other flag says the recorded page translation is still good, so the TLB lookup can be skipped.

Cache line eviction and TLB entry replacement each have an invalidation input. Each entry compares itself against these inputs in parallel, and only the matching flag is dropped. All valid flags are also available as two flat vectors, one bit per register.

Top module: `memo_table`

## Requirements
- R1: The table holds one independent entry per register, NREGS entries by default 32, indexed by the 5-bit register number; writing one entry never changes another.
- R2: Each entry holds a 2-bit way, a 7-bit set index, a 19-bit physical page number, a line-valid flag and a translation-valid flag. The read port returns the entry selected by `rd_reg_i` combinationally.
- R3: On a rising clock edge with `wr_en_i` high, the entry `wr_reg_i` takes all five fields from the write inputs.
- R4: A valid flag becomes set only through a write to its own entry.
- R5: When `wr_en_i` is high and `wr_reg_i` equals `rd_reg_i`, the read outputs show the write inputs in that same cycle.
- R6: An edge with `evict_en_i` high clears the line-valid flag of every entry whose stored set equals `evict_set_i` and whose stored way equals `evict_way_i`. Translation flags and all other entries are left unchanged.
- R7: An edge with `tlb_inv_en_i` high clears the translation-valid flag of every entry whose stored page number equals `tlb_inv_ppn_i`. Line-valid flags are left unchanged.
- R8: If a write and an invalidation hit the same entry on one edge, the entry takes the written values.
- R9: While `rst_ni` is low, every valid flag and every field reads zero.
- R10: Bit r of `line_vld_vec_o` and `xlat_vld_vec_o` is the stored line-valid and translation-valid flag of entry r. These vectors reflect writes only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write the entry of `wr_reg_i` |
| wr_reg_i | input | 5 | Destination register of the preparation operation |
| wr_way_i | input | 2 | Data-cache way to record |
| wr_set_i | input | 7 | Cache set index to record |
| wr_ppn_i | input | 19 | Physical page number to record |
| wr_line_vld_i | input | 1 | Line-valid flag to record |
| wr_xlat_vld_i | input | 1 | Translation-valid flag to record |
| rd_reg_i | input | 5 | Base register of the load or store |
| rd_way_o | output | 2 | Recorded way |
| rd_set_o | output | 7 | Recorded set index |
| rd_ppn_o | output | 19 | Recorded page number |
| rd_line_vld_o | output | 1 | Way is valid: no tag compare is needed |
| rd_xlat_vld_o | output | 1 | Translation is valid: no TLB lookup is needed |
| evict_en_i | input | 1 | A cache line is being replaced |
| evict_set_i | input | 7 | Set of the replaced line |
| evict_way_i | input | 2 | Way of the replaced line |
| tlb_inv_en_i | input | 1 | A TLB entry is being replaced |
| tlb_inv_ppn_i | input | 19 | Page number of the replaced TLB entry |
| line_vld_vec_o | output | 32 | All line-valid flags |
| xlat_vld_vec_o | output | 32 | All translation-valid flags |

## Verification
The bench builds the block with its default parameters: 32 entries, 4 ways, a 7-bit set index and a 19-bit page number. Set indices and page numbers are drawn from pools of four values each, so eviction and TLB invalidation usually hit several entries at once. Writes, reads and invalidations often land on the same register in the same cycle, which exercises same-edge write priority and the read bypass. A reset in the middle of the run checks that a populated table is cleared.

// File: rtl/memo_pkg.sv
package memo_pkg;
  localparam int unsigned NREGS_DEF = 32;
  localparam int unsigned WAYS_DEF  = 4;
  localparam int unsigned SET_W_DEF = 7;
  localparam int unsigned PPN_W_DEF = 19;

  function automatic int unsigned clog2_min1(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/memo_payload.sv
module memo_payload #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned SET_W = 7,
  parameter int unsigned PPN_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RIDX_W-1:0] wr_reg_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  output logic [WAY_W-1:0]  way_o [NREGS],
  output logic [SET_W-1:0]  set_o [NREGS],
  output logic [PPN_W-1:0]  ppn_o [NREGS]
);
  for (genvar r = 0; r < NREGS; r++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        way_o[r] <= '0;
        set_o[r] <= '0;
        ppn_o[r] <= '0;
      end else if (wr_en_i && wr_reg_i == RIDX_W'(r)) begin
        way_o[r] <= wr_way_i;
        set_o[r] <= wr_set_i;
        ppn_o[r] <= wr_ppn_i;
      end
    end

    // R3: written entry holds the written page next cycle
    p_write_ppn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_reg_i == RIDX_W'(r)) |=> ppn_o[r] == $past(wr_ppn_i));
  end
endmodule

// File: rtl/memo_valid.sv
module memo_valid #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned RIDX_W = 5,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned SET_W = 7,
  parameter int unsigned PPN_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RIDX_W-1:0] wr_reg_i,
  input  logic              wr_line_vld_i,
  input  logic              wr_xlat_vld_i,
  input  logic [WAY_W-1:0]  ent_way_i [NREGS],
  input  logic [SET_W-1:0]  ent_set_i [NREGS],
  input  logic [PPN_W-1:0]  ent_ppn_i [NREGS],
  input  logic              evict_en_i,
  input  logic [SET_W-1:0]  evict_set_i,
  input  logic [WAY_W-1:0]  evict_way_i,
  input  logic              tlb_inv_en_i,
  input  logic [PPN_W-1:0]  tlb_inv_ppn_i,
  output logic [NREGS-1:0]  line_q_o,
  output logic [NREGS-1:0]  xlat_q_o
);
  logic [NREGS-1:0] wr_hit, ev_hit, tlb_hit;

  for (genvar r = 0; r < NREGS; r++) begin : g_vld
    assign wr_hit[r]  = wr_en_i && wr_reg_i == RIDX_W'(r);
    assign ev_hit[r]  = evict_en_i && ent_set_i[r] == evict_set_i && ent_way_i[r] == evict_way_i;
    assign tlb_hit[r] = tlb_inv_en_i && ent_ppn_i[r] == tlb_inv_ppn_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q_o[r] <= 1'b0;
        xlat_q_o[r] <= 1'b0;
      end else if (wr_hit[r]) begin
        line_q_o[r] <= wr_line_vld_i;
        xlat_q_o[r] <= wr_xlat_vld_i;
      end else begin
        if (ev_hit[r])  line_q_o[r] <= 1'b0;
        if (tlb_hit[r]) xlat_q_o[r] <= 1'b0;
      end
    end

    p_evict_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_hit[r] && !wr_hit[r]) |=> !line_q_o[r]);
    p_tlb_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tlb_hit[r] && !wr_hit[r]) |=> !xlat_q_o[r]);
    p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[r] |=> (line_q_o[r] == $past(wr_line_vld_i)) && (xlat_q_o[r] == $past(wr_xlat_vld_i)));
    p_no_spurious_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit[r] |=> !$rose(line_q_o[r]) && !$rose(xlat_q_o[r]));
  end
endmodule

// File: rtl/memo_table.sv
module memo_table
  import memo_pkg::*;
#(
  parameter int unsigned NREGS = NREGS_DEF,
  parameter int unsigned WAYS  = WAYS_DEF,
  parameter int unsigned SET_W = SET_W_DEF,
  parameter int unsigned PPN_W = PPN_W_DEF,
  localparam int unsigned RIDX_W = clog2_min1(NREGS),
  localparam int unsigned WAY_W  = clog2_min1(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RIDX_W-1:0] wr_reg_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              wr_line_vld_i,
  input  logic              wr_xlat_vld_i,
  input  logic [RIDX_W-1:0] rd_reg_i,
  output logic [WAY_W-1:0]  rd_way_o,
  output logic [SET_W-1:0]  rd_set_o,
  output logic [PPN_W-1:0]  rd_ppn_o,
  output logic              rd_line_vld_o,
  output logic              rd_xlat_vld_o,
  input  logic              evict_en_i,
  input  logic [SET_W-1:0]  evict_set_i,
  input  logic [WAY_W-1:0]  evict_way_i,
  input  logic              tlb_inv_en_i,
  input  logic [PPN_W-1:0]  tlb_inv_ppn_i,
  output logic [NREGS-1:0]  line_vld_vec_o,
  output logic [NREGS-1:0]  xlat_vld_vec_o
);
  logic [WAY_W-1:0] way_q [NREGS];
  logic [SET_W-1:0] set_q [NREGS];
  logic [PPN_W-1:0] ppn_q [NREGS];
  logic [NREGS-1:0] line_q, xlat_q;
  logic             byp;

  memo_payload #(.NREGS(NREGS), .RIDX_W(RIDX_W), .WAY_W(WAY_W), .SET_W(SET_W), .PPN_W(PPN_W)) u_payload (
    .clk_i, .rst_ni, .wr_en_i, .wr_reg_i, .wr_way_i, .wr_set_i, .wr_ppn_i,
    .way_o(way_q), .set_o(set_q), .ppn_o(ppn_q)
  );

  memo_valid #(.NREGS(NREGS), .RIDX_W(RIDX_W), .WAY_W(WAY_W), .SET_W(SET_W), .PPN_W(PPN_W)) u_valid (
    .clk_i, .rst_ni, .wr_en_i, .wr_reg_i, .wr_line_vld_i, .wr_xlat_vld_i,
    .ent_way_i(way_q), .ent_set_i(set_q), .ent_ppn_i(ppn_q),
    .evict_en_i, .evict_set_i, .evict_way_i, .tlb_inv_en_i, .tlb_inv_ppn_i,
    .line_q_o(line_q), .xlat_q_o(xlat_q)
  );

  // same-cycle write to the read register is forwarded
  assign byp = wr_en_i && wr_reg_i == rd_reg_i;

  always_comb begin
    if (byp) begin
      rd_way_o      = wr_way_i;
      rd_set_o      = wr_set_i;
      rd_ppn_o      = wr_ppn_i;
      rd_line_vld_o = wr_line_vld_i;
      rd_xlat_vld_o = wr_xlat_vld_i;
    end else begin
      rd_way_o      = way_q[rd_reg_i];
      rd_set_o      = set_q[rd_reg_i];
      rd_ppn_o      = ppn_q[rd_reg_i];
      rd_line_vld_o = line_q[rd_reg_i];
      rd_xlat_vld_o = xlat_q[rd_reg_i];
    end
  end

  assign line_vld_vec_o = line_q;
  assign xlat_vld_vec_o = xlat_q;

  p_read_vec_agree_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp |-> (rd_line_vld_o == line_vld_vec_o[rd_reg_i]) && (rd_xlat_vld_o == xlat_vld_vec_o[rd_reg_i]));
endmodule

// File: tb/memo_table_test.sv
module memo_table_test;
  localparam int NR = 32;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wr_line_vld_i = 0, wr_xlat_vld_i = 0;
  logic [4:0] wr_reg_i = 0, rd_reg_i = 0;
  logic [1:0] wr_way_i = 0, evict_way_i = 0, rd_way_o;
  logic [6:0] wr_set_i = 0, evict_set_i = 0, rd_set_o;
  logic [18:0] wr_ppn_i = 0, tlb_inv_ppn_i = 0, rd_ppn_o;
  logic evict_en_i = 0, tlb_inv_en_i = 0, rd_line_vld_o, rd_xlat_vld_o;
  logic [31:0] line_vld_vec_o, xlat_vld_vec_o;

  int n_chk = 0, n_bad = 0;
  int m_way[NR], m_set[NR], m_ppn[NR];
  bit m_line[NR], m_xlat[NR];

  always #5 clk = ~clk;

  memo_table uut (.clk_i(clk), .*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NR; r++) begin
      m_way[r] = 0; m_set[r] = 0; m_ppn[r] = 0; m_line[r] = 0; m_xlat[r] = 0;
    end
  endtask

  function automatic logic [31:0] vec(input bit line);
    logic [31:0] v;
    for (int r = 0; r < NR; r++) v[r] = line ? m_line[r] : m_xlat[r];
    return v;
  endfunction

  task automatic compare();
    bit byp = wr_en_i && wr_reg_i == rd_reg_i;
    int r = rd_reg_i;
    if (byp) begin // R5
      chk("R5 way", rd_way_o, wr_way_i);
      chk("R5 set", rd_set_o, wr_set_i);
      chk("R5 ppn", rd_ppn_o, wr_ppn_i);
      chk("R5 line", rd_line_vld_o, wr_line_vld_i);
      chk("R5 xlat", rd_xlat_vld_o, wr_xlat_vld_i);
    end else begin // R1 R2 R3
      chk("R2 R3 way", rd_way_o, m_way[r]);
      chk("R2 R3 set", rd_set_o, m_set[r]);
      chk("R2 R3 ppn", rd_ppn_o, m_ppn[r]);
      chk("R4 R6 R8 line", rd_line_vld_o, m_line[r]);
      chk("R4 R7 R8 xlat", rd_xlat_vld_o, m_xlat[r]);
    end
    chk("R1 R6 R10 line vector", line_vld_vec_o, vec(1));
    chk("R1 R7 R10 xlat vector", xlat_vld_vec_o, vec(0));
  endtask

  // next-edge state; write to an entry overrides invalidation (R8)
  task automatic model_edge();
    bit ev[NR], tl[NR];
    for (int r = 0; r < NR; r++) begin
      ev[r] = evict_en_i && m_set[r] == evict_set_i && m_way[r] == evict_way_i;
      tl[r] = tlb_inv_en_i && m_ppn[r] == tlb_inv_ppn_i;
    end
    for (int r = 0; r < NR; r++) begin
      if (wr_en_i && wr_reg_i == r) begin
        m_way[r] = wr_way_i; m_set[r] = wr_set_i; m_ppn[r] = wr_ppn_i;
        m_line[r] = wr_line_vld_i; m_xlat[r] = wr_xlat_vld_i;
      end else begin
        if (ev[r]) m_line[r] = 0;
        if (tl[r]) m_xlat[r] = 0;
      end
    end
  endtask

  task automatic drive_rand(input int wr_pct, input int inv_pct);
    wr_en_i = ($urandom % 100) < wr_pct;
    wr_reg_i = 5'($urandom);
    rd_reg_i = ($urandom % 4 == 0) ? wr_reg_i : 5'($urandom);
    wr_way_i = 2'($urandom);
    wr_set_i = 7'(8 * ($urandom % 4));
    wr_ppn_i = 19'(19'h1000 + ($urandom % 4));
    wr_line_vld_i = ($urandom % 8) != 0;
    wr_xlat_vld_i = ($urandom % 8) != 0;
    evict_en_i = ($urandom % 100) < inv_pct;
    evict_set_i = 7'(8 * ($urandom % 4));
    evict_way_i = 2'($urandom);
    tlb_inv_en_i = ($urandom % 100) < inv_pct;
    tlb_inv_ppn_i = 19'(19'h1000 + ($urandom % 4));
  endtask

  task automatic run(input int cycles, input int wr_pct, input int inv_pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      drive_rand(wr_pct, inv_pct);
      #1;
      compare();
      model_edge();
    end
  endtask

  initial begin
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R9: reset state with write attempted
    wr_en_i = 1; wr_line_vld_i = 1; wr_xlat_vld_i = 1; wr_reg_i = 5'd3; rd_reg_i = 5'd4;
    @(negedge clk);
    chk("R9 line vector", line_vld_vec_o, 0);
    chk("R9 xlat vector", xlat_vld_vec_o, 0);
    chk("R9 ppn", rd_ppn_o, 0);
    wr_en_i = 0;
    rst_ni = 1;
    // fill every entry, read back (R1 R3)
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      wr_en_i = 1; wr_reg_i = 5'(r); wr_way_i = 2'(r); wr_set_i = 7'(8 * (r % 4));
      wr_ppn_i = 19'(19'h1000 + r % 4); wr_line_vld_i = 1; wr_xlat_vld_i = 1;
      rd_reg_i = 5'(r + 1); evict_en_i = 0; tlb_inv_en_i = 0;
      #1; compare(); model_edge();
    end
    // R6: single eviction of set 8 way 1
    @(negedge clk);
    wr_en_i = 0; evict_en_i = 1; evict_set_i = 7'd8; evict_way_i = 2'd1;
    #1; compare(); model_edge();
    // R7: TLB replacement of page 0x1002
    @(negedge clk);
    evict_en_i = 0; tlb_inv_en_i = 1; tlb_inv_ppn_i = 19'h1002;
    #1; compare(); model_edge();
    // R8: write and eviction to same entry on one edge
    @(negedge clk);
    tlb_inv_en_i = 0; evict_en_i = 1; evict_set_i = 7'd0; evict_way_i = 2'd0;
    wr_en_i = 1; wr_reg_i = 5'd0; wr_set_i = 7'd0; wr_way_i = 2'd0; rd_reg_i = 5'd4;
    #1; compare(); model_edge();
    @(negedge clk);
    wr_en_i = 0; evict_en_i = 0; rd_reg_i = 5'd0;
    #1; compare(); model_edge();
    run(3000, 40, 10);
    run(2000, 10, 40);
    // R9: mid-run reset clears a populated table
    @(negedge clk);
    wr_en_i = 0; evict_en_i = 0; tlb_inv_en_i = 0;
    rst_ni = 0; model_clear();
    #1; compare();
    @(negedge clk);
    rst_ni = 1;
    run(2000, 50, 20);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule